// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

The controller gathers up to `N_SRC` maskable request sources and decides which one, if any, the CPU takes next. Every source holds a sticky pending bit and a 3-bit level. A global enable flag and a 3-bit processor priority threshold gate acceptance. Among the eligible sources the one with the highest level is presented to the CPU as an interrupt line plus a source index. A one-cycle acknowledge clears that source's pending bit.

Software reaches the per-source state through a small write port addressed by source index. It can program a level or clear a pending bit, but it can never create a request. A second write port loads the enable flag and the threshold. All outputs are combinational from registered state and from the port select, so the CPU sees a decision in the same cycle that the state settles.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While the enable flag `ien_o` is 0, `irq_o` stays 0 whatever the pending bits, levels and threshold are.
- R2: A 1 on `req_evt_i[i]` at a clock edge sets pending bit i. The bit stays 1 until it is acknowledged or cleared by software.
- R3: `ack_i` high while `irq_o` is 1 clears the pending bit of source `irq_idx_o` at that edge. `ack_i` while `irq_o` is 0 changes nothing.
- R4: With `reg_req_we_i` high, a `reg_req_i` of 0 clears the pending bit of source `reg_sel_i`. A `reg_req_i` of 1 leaves that bit unchanged.
- R5: Each source has a 3-bit level, written through `reg_lvl_we_i`/`reg_lvl_i` and read back on `rd_lvl_o` for source `reg_sel_i`. Level 0 means the source is never accepted, and 7 is the most urgent level.
- R6: `irq_o` is 1 exactly when some source has its pending bit set, a level strictly above `ipl_o`, and `ien_o` is 1. The decision is made in the same cycle from the registered state.
- R7: A threshold of 7 blocks every source. A threshold of 0 admits levels 1 to 7.
- R8: The enable flag, the threshold, the pending bits and the levels are separate state. A write to any one of them leaves all the others unchanged.
- R9: `irq_idx_o` names the eligible source with the highest level. When levels are equal, the lowest index wins. When `irq_o` is 0, `irq_idx_o` is 0.
- R10: If a request event arrives in the same cycle as a software clear or an acknowledge of that source, the pending bit ends up 1.
- R11: Reset clears all pending bits, all levels, the enable flag and the threshold to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_evt_i | input | N_SRC | Per-source request event pulses |
| reg_sel_i | input | IDX_W | Source addressed by the register port |
| reg_lvl_we_i | input | 1 | Write the level of the addressed source |
| reg_lvl_i | input | 3 | Level write data |
| reg_req_we_i | input | 1 | Write the pending bit of the addressed source (0 clears, 1 ignored) |
| reg_req_i | input | 1 | Pending-bit write data |
| cpu_we_i | input | 1 | Load enable flag and threshold |
| cpu_ien_i | input | 1 | Enable flag write data |
| cpu_ipl_i | input | 3 | Threshold write data |
| ack_i | input | 1 | CPU acknowledge pulse |
| irq_o | output | 1 | Interrupt to CPU |
| irq_idx_o | output | IDX_W | Index of the selected source |
| pend_o | output | N_SRC | Pending bits |
| ien_o | output | 1 | Enable flag |
| ipl_o | output | 3 | Processor priority threshold |
| rd_lvl_o | output | 3 | Level of the addressed source |

## Verification
The bench builds the controller with `N_SRC = 8`, a power of two, so every index the select port can carry addresses a real source. With eight sources, one cycle can hold several ties at one level, a lower-level source at a lower index, and a level-0 source that is pending. A long random phase runs at every threshold value with dense request events. Because of that density, event-versus-clear and event-versus-acknowledge collisions on the same source occur often. The random phase is compared cycle by cycle against a behavioural model.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_prio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic lvl_we_i,
  input  lvl_t lvl_i,
  output logic pend_o,
  output lvl_t lvl_o
);
  logic pend_q;
  lvl_t lvl_q;

  // event has precedence over any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (evt_i)    pend_q <= 1'b1;
    else if (clr_i)    pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lvl_q <= '0;
    else if (lvl_we_i) lvl_q <= lvl_i;
  end

  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pend_o); // R2
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && clr_i) |=> pend_o); // R10
  AST_NO_SELF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !pend_o) |=> !pend_o); // R4
  AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_we_i |=> $stable(lvl_o)); // R8
endmodule

// File: rtl/irq_cpu_state.sv
module irq_cpu_state
  import irq_prio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic ien_i,
  input  lvl_t ipl_i,
  output logic ien_o,
  output lvl_t ipl_o
);
  logic ien_q;
  lvl_t ipl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= 1'b0;
      ipl_q <= '0;
    end else if (we_i) begin
      ien_q <= ien_i;
      ipl_q <= ipl_i;
    end
  end

  assign ien_o = ien_q;
  assign ipl_o = ipl_q;

  AST_CPU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(ien_o) && $stable(ipl_o))); // R8
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]            pend_i,
  input  lvl_t [N_SRC-1:0]            lvl_i,
  input  logic                        ien_i,
  input  lvl_t                        ipl_i,
  output logic                        irq_o,
  output logic [IDX_W-1:0]            idx_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    lvl_t best;
    irq_o = 1'b0;
    idx_o = '0;
    best  = ipl_i;
    for (int i = 0; i < N_SRC; i++) begin
      if (ien_i && pend_i[i] && (lvl_i[i] > best)) begin
        irq_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_evt_i,
  input  logic [IDX_W-1:0]  reg_sel_i,
  input  logic              reg_lvl_we_i,
  input  logic [LVL_W-1:0]  reg_lvl_i,
  input  logic              reg_req_we_i,
  input  logic              reg_req_i,
  input  logic              cpu_we_i,
  input  logic              cpu_ien_i,
  input  logic [LVL_W-1:0]  cpu_ipl_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic [N_SRC-1:0]  pend_o,
  output logic              ien_o,
  output logic [LVL_W-1:0]  ipl_o,
  output logic [LVL_W-1:0]  rd_lvl_o
);
  lvl_t [N_SRC-1:0] lvl_w;
  logic [N_SRC-1:0] pend_w;
  logic             ien_w;
  lvl_t             ipl_w;
  logic             irq_w;
  logic [IDX_W-1:0] idx_w;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic hit, sw_clr, ack_clr;
    assign hit     = (reg_sel_i == IDX_W'(g));
    assign sw_clr  = reg_req_we_i && hit && !reg_req_i;
    assign ack_clr = ack_i && irq_w && (idx_w == IDX_W'(g));

    irq_src_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (req_evt_i[g]),
      .clr_i    (sw_clr || ack_clr),
      .lvl_we_i (reg_lvl_we_i && hit),
      .lvl_i    (reg_lvl_i),
      .pend_o   (pend_w[g]),
      .lvl_o    (lvl_w[g])
    );
  end

  irq_cpu_state u_cpu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cpu_we_i),
    .ien_i  (cpu_ien_i),
    .ipl_i  (cpu_ipl_i),
    .ien_o  (ien_w),
    .ipl_o  (ipl_w)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend_i (pend_w),
    .lvl_i  (lvl_w),
    .ien_i  (ien_w),
    .ipl_i  (ipl_w),
    .irq_o  (irq_w),
    .idx_o  (idx_w)
  );

  assign irq_o     = irq_w;
  assign irq_idx_o = idx_w;
  assign pend_o    = pend_w;
  assign ien_o     = ien_w;
  assign ipl_o     = ipl_w;
  assign rd_lvl_o  = lvl_w[reg_sel_i];

  AST_IRQ_NEEDS_IEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien_o); // R1
  AST_IRQ_ABOVE_IPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_o[irq_idx_o] && (lvl_w[irq_idx_o] > ipl_o))); // R6
  AST_IPL_MAX_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl_o == lvl_t'(LVL_MAX)) |-> !irq_o); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !req_evt_i[irq_idx_o]) |=> !pend_o[$past(irq_idx_o)]); // R3
  AST_IDLE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_idx_o == '0)); // R9
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_evt;
  logic [IW-1:0] reg_sel;
  logic reg_lvl_we, reg_req_we, reg_req, cpu_we, cpu_ien, ack;
  logic [2:0] reg_lvl, cpu_ipl;
  logic irq;
  logic [IW-1:0] irq_idx;
  logic [N-1:0] pend;
  logic ien;
  logic [2:0] ipl, rd_lvl;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;
  int pend_m[N], lvl_m[N], ien_m, ipl_m;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_evt_i(req_evt), .reg_sel_i(reg_sel),
    .reg_lvl_we_i(reg_lvl_we), .reg_lvl_i(reg_lvl), .reg_req_we_i(reg_req_we),
    .reg_req_i(reg_req), .cpu_we_i(cpu_we), .cpu_ien_i(cpu_ien), .cpu_ipl_i(cpu_ipl),
    .ack_i(ack), .irq_o(irq), .irq_idx_o(irq_idx), .pend_o(pend), .ien_o(ien),
    .ipl_o(ipl), .rd_lvl_o(rd_lvl));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // model selection: scan levels from top, lowest index first
  function automatic int pick(output int idx);
    idx = 0;
    if (ien_m == 0) return 0;
    for (int lv = 7; lv > ipl_m; lv--)
      for (int i = 0; i < N; i++)
        if (pend_m[i] == 1 && lvl_m[i] == lv) begin idx = i; return 1; end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin pend_m[i] = 0; lvl_m[i] = 0; end
      ien_m = 0; ipl_m = 0;
    end else begin
      int v, s;
      v = pick(s);
      for (int i = 0; i < N; i++) begin
        if (reg_req_we && reg_sel == i && !reg_req) pend_m[i] = 0;
        if (ack && v == 1 && s == i) pend_m[i] = 0;
        if (req_evt[i]) pend_m[i] = 1;
        if (reg_lvl_we && reg_sel == i) lvl_m[i] = reg_lvl;
      end
      if (cpu_we) begin ien_m = cpu_ien; ipl_m = cpu_ipl; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int v, s, pv;
      #2;
      v = pick(s);
      pv = 0;
      for (int i = 0; i < N; i++) pv |= pend_m[i] << i;
      chk("R6 irq_o", irq, v);
      chk("R9 irq_idx_o", irq_idx, s);
      chk("R2 pend_o", pend, pv);
      chk("R8 ien_o", ien, ien_m);
      chk("R8 ipl_o", ipl, ipl_m);
      chk("R5 rd_lvl_o", rd_lvl, lvl_m[reg_sel]);
    end
  end

  task automatic clr_in();
    req_evt = '0; reg_sel = '0; reg_lvl_we = 0; reg_lvl = '0; reg_req_we = 0;
    reg_req = 0; cpu_we = 0; cpu_ien = 0; cpu_ipl = '0; ack = 0;
  endtask

  task automatic go();
    @(negedge clk); clr_in(); #1;
  endtask

  task automatic set_lvl(int s, int l);
    go(); reg_sel = IW'(s); reg_lvl_we = 1; reg_lvl = 3'(l);
  endtask

  task automatic set_cpu(int e, int p);
    go(); cpu_we = 1; cpu_ien = e[0]; cpu_ipl = 3'(p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clr_in();
    repeat (3) @(negedge clk);
    #1;
    chk("R11 pend_o", pend, 0);
    chk("R11 ien_o", ien, 0);
    chk("R11 ipl_o", ipl, 0);
    chk("R11 irq_o", irq, 0);
    rst_n = 1;
    cmp_on = 1;
    chk("R11 rd_lvl_o", rd_lvl, 0);

    set_lvl(2, 5); set_lvl(5, 5); set_lvl(6, 3); set_lvl(1, 0);
    go(); req_evt = 8'b0110_0110;
    go();
    chk("R1 irq_o while disabled", irq, 0);
    chk("R2 pend_o sticky", pend, 8'b0110_0110);
    set_cpu(1, 0);
    go();
    chk("R9 tie irq_o", irq, 1);
    chk("R9 tie lowest index", irq_idx, 2);
    ack = 1;
    go();
    chk("R3 ack clears", pend, 8'b0110_0010);
    chk("R9 next winner", irq_idx, 5);
    set_cpu(1, 5);
    go();
    chk("R6 strict compare", irq, 0);
    ack = 1;
    go();
    chk("R3 ack ignored when idle", pend, 8'b0110_0010);
    set_cpu(1, 2);
    go();
    chk("R6 above ipl", irq_idx, 5);
    set_cpu(1, 7);
    go();
    chk("R7 ipl 7 blocks", irq, 0);
    set_cpu(0, 0);
    go();
    chk("R1 disable blocks", irq, 0);
    reg_sel = 0; reg_req_we = 1; reg_req = 1;
    go();
    chk("R4 write one ignored", pend, 8'b0110_0010);
    reg_sel = 5; reg_req_we = 1; reg_req = 0;
    go();
    chk("R4 write zero clears", pend, 8'b0100_0010);
    reg_sel = 6; reg_req_we = 1; reg_req = 0; req_evt = 8'b0100_0000;
    go();
    chk("R10 event beats clear", pend, 8'b0100_0010);
    set_cpu(1, 0);
    go(); ack = 1; req_evt = 8'b0100_0000;
    go();
    chk("R10 event beats ack", pend, 8'b0100_0010);
    reg_sel = 2;
    #1 chk("R8 level kept", rd_lvl, 5);
    chk("R5 level 0 source ignored", irq_idx, 6);

    for (int c = 0; c < 4000; c++) begin
      go();
      req_evt = N'($urandom) & N'($urandom);
      reg_sel = IW'($urandom);
      reg_lvl_we = ($urandom % 6) == 0;
      reg_lvl = 3'($urandom);
      reg_req_we = ($urandom % 4) == 0;
      reg_req = 1'($urandom);
      cpu_we = ($urandom % 10) == 0;
      cpu_ien = ($urandom % 5) != 0;
      cpu_ipl = 3'($urandom);
      ack = 1'($urandom);
    end
    go();
    go();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule